// File: doc/BRIEF.md
# Link Width and Speed Field Synchronizer

This block owns the link-related fields of a port's capability structure. From a configured maximum lane count and maximum speed code it derives, one clock later, the capability fields: the maximum width and speed, a bandwidth-notification-capable flag, a link-active-reporting-capable flag, a supported-speeds vector and the default target speed. These capability fields are registered, so the rest of the port sees stable values.

It also keeps the port's negotiated link status word. A single-cycle sync strobe takes the status reported by the downstream device. The reported width and speed are limited to the port's capability, and zero values are replaced by one lane at the lowest rate. If no downstream device is present, the capability fields are copied instead. Only the width and speed fields of the status word are written by a sync. The remaining status bits come from the port's own flags and are never taken from the downstream word.

Top module: `lnk_fields_sync`

## Requirements
- R1: Bandwidth-notification-capable is 1 one clock after the configured width is above 1 lane or the configured speed code is above 1 (2.5 GT/s), and 0 otherwise. Capability width and speed equal the configured values one clock later.
- R2: Link-active-reporting-capable is 1 one clock after the configured speed code is above 1, and 0 otherwise.
- R3: The target speed output equals the configured speed code one clock later when that code is above 1, and is 0 when the code is 1.
- R4: In the supported-speeds vector, bit 0 stands for 2.5, bit 1 for 5, bit 2 for 8 and bit 3 for 16 GT/s. The vector is 0 for speed codes 1 and 2, 4'b0111 for code 3 and 4'b1111 for code 4. Speed codes are 1=2.5, 2=5, 3=8 and 4=16 GT/s.
- R5: In the status word, speed is in bits 3:0 and the lane count is in bits 9:4. One clock after a sync with no downstream device present, both fields equal the capability width and speed.
- R6: One clock after a sync with a device present, the status width is the reported width (downstream bits 9:4). A reported width above the capability width is replaced by the capability width, and a reported width of 0 by 1.
- R7: One clock after a sync with a device present, the status speed is the reported speed (downstream bits 3:0). A reported speed above the capability speed is replaced by the capability speed, and a reported speed of 0 by 1.
- R8: Status bits 15:10 equal the port flags input one clock earlier and never take bits from the downstream word.
- R9: Without a sync strobe, the status width and speed keep their values even when the downstream word or the presence flag changes.
- R10: After reset, capability width and speed and status width and speed are 1. Both capability flags, the speed vector, the target speed and the status flag bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 6 | Configured maximum lane count |
| cfg_speed | input | 4 | Configured maximum speed code |
| sync_req | input | 1 | One-cycle strobe that updates status width and speed |
| dn_present | input | 1 | A downstream device is present |
| dn_status | input | 16 | Status word reported by the downstream device |
| port_flags | input | 6 | Port-owned status bits for bits 15:10 |
| cap_max_width | output | 6 | Capability maximum lane count |
| cap_max_speed | output | 4 | Capability maximum speed code |
| cap_bw_notify | output | 1 | Bandwidth-notification-capable flag |
| cap_active_rpt | output | 1 | Link-active-reporting-capable flag |
| cap2_rate_vec | output | 4 | Supported-speeds vector |
| ctl2_tgt_speed | output | 4 | Default target link speed |
| sta_word | output | 16 | Link status word |

## Verification
A wrong capability register shows on the capability outputs on the clock edge after the configuration is applied, and also in the status width or speed after the next sync that clamps against it. A wrong clamp or default in the status path shows on the status word one clock after the sync strobe and stays there until the next strobe. Any disturbance of the held status fields between strobes is therefore visible on every later cycle. The reference model is compared against all outputs on every clock, so the first mismatching edge is reported.

// File: rtl/lnk_fields_pkg.sv
package lnk_fields_pkg;
  parameter int unsigned LANE_W    = 6;
  parameter int unsigned SPD_W     = 4;
  parameter int unsigned NUM_RATES = 4;
  parameter int unsigned STA_W     = 16;

  localparam int unsigned FLAG_W   = STA_W - SPD_W - LANE_W;
  localparam logic [SPD_W-1:0]  SPD_LOWEST = SPD_W'(1);
  localparam logic [SPD_W-1:0]  SPD_SECOND = SPD_W'(2);
  localparam logic [LANE_W-1:0] LANES_ONE  = LANE_W'(1);

  // Pick a lane count: take the reported value, limit it to the maximum, and use one lane for zero.
  function automatic logic [LANE_W-1:0] fit_lanes(input logic [LANE_W-1:0] rep,
                                                  input logic [LANE_W-1:0] cap);
    logic [LANE_W-1:0] r;
    if (rep > cap)           r = cap;
    else if (rep == '0)      r = LANES_ONE;
    else                     r = rep;
    return r;
  endfunction

  // Pick a speed code the same way: limit it to the maximum, and use the lowest rate for zero.
  function automatic logic [SPD_W-1:0] fit_speed(input logic [SPD_W-1:0] rep,
                                                 input logic [SPD_W-1:0] cap);
    logic [SPD_W-1:0] r;
    if (rep > cap)           r = cap;
    else if (rep == '0)      r = SPD_LOWEST;
    else                     r = rep;
    return r;
  endfunction

  // The vector lists rates only when the maximum is above the second rate.
  // Bit i stands for speed code i+1.
  function automatic logic [NUM_RATES-1:0] rate_list(input logic [SPD_W-1:0] spd);
    logic [NUM_RATES-1:0] v;
    v = '0;
    if (spd > SPD_SECOND) begin
      for (int i = 0; i < NUM_RATES; i++) begin
        v[i] = (32'(spd) >= 32'(i + 1));
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/lnk_cap_build.sv
module lnk_cap_build
  import lnk_fields_pkg::*;
#(
  parameter int unsigned P_LANE_W    = LANE_W,
  parameter int unsigned P_SPD_W     = SPD_W,
  parameter int unsigned P_NUM_RATES = NUM_RATES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [P_LANE_W-1:0]    cfg_width,
  input  logic [P_SPD_W-1:0]     cfg_speed,
  output logic [P_LANE_W-1:0]    max_width,
  output logic [P_SPD_W-1:0]     max_speed,
  output logic                   bw_notify,
  output logic                   active_rpt,
  output logic [P_NUM_RATES-1:0] rate_vec,
  output logic [P_SPD_W-1:0]     tgt_speed
);
  logic                   multi_lane;
  logic                   above_lowest;
  logic [P_NUM_RATES-1:0] rate_next;

  assign multi_lane   = (cfg_width > P_LANE_W'(1));
  assign above_lowest = (cfg_speed > P_SPD_W'(1));
  assign rate_next    = P_NUM_RATES'(rate_list(SPD_W'(cfg_speed)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      max_width  <= P_LANE_W'(1);
      max_speed  <= P_SPD_W'(1);
      bw_notify  <= 1'b0;
      active_rpt <= 1'b0;
      rate_vec   <= '0;
      tgt_speed  <= '0;
    end else begin
      max_width  <= cfg_width;
      max_speed  <= cfg_speed;
      bw_notify  <= multi_lane | above_lowest;
      active_rpt <= above_lowest;
      rate_vec   <= rate_next;
      tgt_speed  <= above_lowest ? cfg_speed : '0;
    end
  end

  // R1: a multi-lane maximum always advertises bandwidth notification
  p_bw_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (max_width > P_LANE_W'(1)) |-> bw_notify);

  // R2: link-active reporting implies bandwidth notification
  p_active_bw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_rpt |-> bw_notify);

  // R3: a nonzero target speed is the maximum speed and comes with active reporting
  p_tgt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_speed != '0) |-> (active_rpt && tgt_speed == max_speed));

  // R4: the vector is empty, or it lists a contiguous set from the lowest rate
  p_vec_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_vec != '0) |-> (rate_vec[0] && rate_vec[1] && rate_vec[2] && active_rpt));
endmodule

// File: rtl/lnk_sta_sync.sv
module lnk_sta_sync
  import lnk_fields_pkg::*;
#(
  parameter int unsigned P_LANE_W = LANE_W,
  parameter int unsigned P_SPD_W  = SPD_W,
  parameter int unsigned P_STA_W  = STA_W,
  localparam int unsigned P_FLAG_W = P_STA_W - P_SPD_W - P_LANE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_req,
  input  logic                dn_present,
  input  logic [P_STA_W-1:0]  dn_status,
  input  logic [P_FLAG_W-1:0] port_flags,
  input  logic [P_LANE_W-1:0] cap_width,
  input  logic [P_SPD_W-1:0]  cap_speed,
  output logic [P_STA_W-1:0]  sta_word
);
  logic [P_LANE_W-1:0] rep_width;
  logic [P_SPD_W-1:0]  rep_speed;
  logic [P_LANE_W-1:0] width_next;
  logic [P_SPD_W-1:0]  speed_next;
  logic [P_LANE_W-1:0] width_q;
  logic [P_SPD_W-1:0]  speed_q;
  logic [P_FLAG_W-1:0] flags_q;
  logic                sync_fire;

  assign rep_width = dn_status[P_SPD_W +: P_LANE_W];
  assign rep_speed = dn_status[0 +: P_SPD_W];
  assign sync_fire = sync_req;

  always_comb begin
    if (dn_present) begin
      width_next = P_LANE_W'(fit_lanes(LANE_W'(rep_width), LANE_W'(cap_width)));
      speed_next = P_SPD_W'(fit_speed(SPD_W'(rep_speed), SPD_W'(cap_speed)));
    end else begin
      width_next = cap_width;
      speed_next = cap_speed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= P_LANE_W'(1);
      speed_q <= P_SPD_W'(1);
      flags_q <= '0;
    end else begin
      flags_q <= port_flags;
      if (sync_fire) begin
        width_q <= width_next;
        speed_q <= speed_next;
      end
    end
  end

  assign sta_word = {flags_q, width_q, speed_q};

  // R5: without a downstream device the status copies the capability
  p_copy_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_req && !dn_present) |->
      (width_q == $past(cap_width) && speed_q == $past(cap_speed)));

  // R6: a synced width from a present device is never zero and never above the maximum
  p_width_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_req && dn_present) |->
      (width_q != '0 && width_q <= $past(cap_width)));

  // R7: the same bounds hold for the synced speed
  p_speed_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_req && dn_present) |->
      (speed_q != '0 && speed_q <= $past(cap_speed)));

  // R9: width and speed hold between strobes
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sync_req) |-> ($stable(width_q) && $stable(speed_q)));
endmodule

// File: rtl/lnk_fields_sync.sv
module lnk_fields_sync
  import lnk_fields_pkg::*;
#(
  parameter int unsigned P_LANE_W    = LANE_W,
  parameter int unsigned P_SPD_W     = SPD_W,
  parameter int unsigned P_NUM_RATES = NUM_RATES,
  parameter int unsigned P_STA_W     = STA_W,
  localparam int unsigned P_FLAG_W   = P_STA_W - P_SPD_W - P_LANE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [P_LANE_W-1:0]    cfg_width,
  input  logic [P_SPD_W-1:0]     cfg_speed,
  input  logic                   sync_req,
  input  logic                   dn_present,
  input  logic [P_STA_W-1:0]     dn_status,
  input  logic [P_FLAG_W-1:0]    port_flags,
  output logic [P_LANE_W-1:0]    cap_max_width,
  output logic [P_SPD_W-1:0]     cap_max_speed,
  output logic                   cap_bw_notify,
  output logic                   cap_active_rpt,
  output logic [P_NUM_RATES-1:0] cap2_rate_vec,
  output logic [P_SPD_W-1:0]     ctl2_tgt_speed,
  output logic [P_STA_W-1:0]     sta_word
);
  lnk_cap_build #(
    .P_LANE_W   (P_LANE_W),
    .P_SPD_W    (P_SPD_W),
    .P_NUM_RATES(P_NUM_RATES)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_width (cfg_width),
    .cfg_speed (cfg_speed),
    .max_width (cap_max_width),
    .max_speed (cap_max_speed),
    .bw_notify (cap_bw_notify),
    .active_rpt(cap_active_rpt),
    .rate_vec  (cap2_rate_vec),
    .tgt_speed (ctl2_tgt_speed)
  );

  lnk_sta_sync #(
    .P_LANE_W(P_LANE_W),
    .P_SPD_W (P_SPD_W),
    .P_STA_W (P_STA_W)
  ) u_sta (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_req  (sync_req),
    .dn_present(dn_present),
    .dn_status (dn_status),
    .port_flags(port_flags),
    .cap_width (cap_max_width),
    .cap_speed (cap_max_speed),
    .sta_word  (sta_word)
  );

  // R8: the port-owned status bits follow the flags input, never the downstream word
  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sta_word[P_STA_W-1 -: P_FLAG_W] == $past(port_flags)));
endmodule

// File: tb/test_lnk_fields_sync.sv
module test_lnk_fields_sync;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  cfg_width;
  logic [3:0]  cfg_speed;
  logic        sync_req;
  logic        dn_present;
  logic [15:0] dn_status;
  logic [5:0]  port_flags;
  logic [5:0]  cap_max_width;
  logic [3:0]  cap_max_speed;
  logic        cap_bw_notify;
  logic        cap_active_rpt;
  logic [3:0]  cap2_rate_vec;
  logic [3:0]  ctl2_tgt_speed;
  logic [15:0] sta_word;

  int errors = 0;
  int checks = 0;
  bit cmp_en = 0;

  // reference model state
  int m_w, m_s, m_bw, m_ar, m_vec, m_tgt;
  int s_w, s_s, s_fl;

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_fields_sync i_lnk_fields_sync (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_speed(cfg_speed),
    .sync_req(sync_req), .dn_present(dn_present), .dn_status(dn_status),
    .port_flags(port_flags), .cap_max_width(cap_max_width),
    .cap_max_speed(cap_max_speed), .cap_bw_notify(cap_bw_notify),
    .cap_active_rpt(cap_active_rpt), .cap2_rate_vec(cap2_rate_vec),
    .ctl2_tgt_speed(ctl2_tgt_speed), .sta_word(sta_word)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_w = 1; m_s = 1; m_bw = 0; m_ar = 0; m_vec = 0; m_tgt = 0;
      s_w = 1; s_s = 1; s_fl = 0;
    end else begin
      if (sync_req) begin
        if (!dn_present) begin
          s_w = m_w; s_s = m_s;
        end else begin
          int rw, rs;
          rw = (dn_status >> 4) & 63;
          rs = dn_status & 15;
          s_w = (rw == 0) ? 1 : ((rw > m_w) ? m_w : rw);
          s_s = (rs == 0) ? 1 : ((rs > m_s) ? m_s : rs);
        end
      end
      s_fl = port_flags;
      m_w = cfg_width; m_s = cfg_speed;
      m_bw = (m_w > 1 || m_s > 1) ? 1 : 0;
      m_ar = (m_s > 1) ? 1 : 0;
      m_tgt = (m_s > 1) ? m_s : 0;
      case (m_s)
        3: m_vec = 7;
        4: m_vec = 15;
        default: m_vec = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R1 cap width", cap_max_width, m_w);
      chk("R1 cap speed", cap_max_speed, m_s);
      chk("R1 bw notify", cap_bw_notify, m_bw);
      chk("R2 active rpt", cap_active_rpt, m_ar);
      chk("R3 target speed", ctl2_tgt_speed, m_tgt);
      chk("R4 rate vector", cap2_rate_vec, m_vec);
      chk("R5 R6 status width", sta_word[9:4], s_w);
      chk("R5 R7 status speed", sta_word[3:0], s_s);
      chk("R8 status flags", sta_word[15:10], s_fl);
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int widths[4] = '{1, 2, 8, 32};
    logic [5:0] held_w;
    logic [3:0] held_s;
    rst_n = 0; cfg_width = 6'd16; cfg_speed = 4'd4; sync_req = 0;
    dn_present = 0; dn_status = 16'hFFFF; port_flags = 6'h3F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset values
    chk("R10 cap width", cap_max_width, 1);
    chk("R10 cap speed", cap_max_speed, 1);
    chk("R10 bw notify", cap_bw_notify, 0);
    chk("R10 active rpt", cap_active_rpt, 0);
    chk("R10 rate vector", cap2_rate_vec, 0);
    chk("R10 target speed", ctl2_tgt_speed, 0);
    chk("R10 status word", sta_word, 16'h0011);
    rst_n = 1;
    cmp_en = 1;
    for (int sp = 1; sp <= 4; sp++) begin
      for (int wi = 0; wi < 4; wi++) begin
        for (int p = 0; p < 5; p++) begin
          @(negedge clk);
          cfg_width  = 6'(widths[wi]);
          cfg_speed  = 4'(sp);
          port_flags = 6'(p * 13 + sp);
          dn_present = (p != 0);
          case (p)
            0: dn_status = 16'hFFFF;
            1: dn_status = {6'h3F, 6'd0, 4'd0};
            2: dn_status = {6'h15, 6'd63, 4'd15};
            3: dn_status = {6'h00, 6'd1, 4'd1};
            default: dn_status = {6'h2A, 6'd2, 4'd2};
          endcase
          @(negedge clk);
          sync_req = 1;
          @(negedge clk);
          sync_req = 0;
        end
      end
    end
    // R9: status holds without a strobe while downstream inputs change
    @(negedge clk);
    held_w = sta_word[9:4];
    held_s = sta_word[3:0];
    dn_present = 1; dn_status = {6'h00, 6'd0, 4'd0};
    repeat (2) @(negedge clk);
    dn_present = 0;
    repeat (2) @(negedge clk);
    chk("R9 held width", sta_word[9:4], held_w);
    chk("R9 held speed", sta_word[3:0], held_s);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule